// File: doc/BRIEF.md
# Big-Endian Byte and Word Load/Store Unit

This unit sits between a processor core and a 32-bit wide, byte-addressed data memory. The core presents a base address, a signed 16-bit displacement, an access kind and, for stores, a source register value. The unit forms the effective address and drives the memory with a word-aligned address. For stores it also drives per-lane write enables and lane-positioned write data. When a load returns a word, the unit extracts the addressed byte and widens it to a full register value with sign extension.

Lanes are mapped big-endian. The byte whose address is the word address sits in the most significant lane, bits [31:24]. A word access whose effective address is not a multiple of four is flagged as misaligned and is dropped: no lane is written and no read is issued. Byte accesses are never misaligned.

The memory-side outputs are registered and appear one cycle after the request. The memory is expected to return read data in the same cycle the read strobe is high. The formatted load result is registered one cycle later.

Top module: `lsu_be_top`

## Requirements
- R1: One clock after a request, mem_addr equals base_addr plus the sign-extended offset, with bits [1:0] forced to zero.
- R2: Access kind encoding on req_kind is 2'b00 byte load, 2'b01 word load, 2'b10 byte store and 2'b11 word store. Bit 1 selects a store and bit 0 selects a word.
- R3: An aligned word store drives mem_we = 4'b1111 and mem_wdata = st_data one clock after the request.
- R4: A byte store at byte offset k (effective address bits [1:0]) sets only mem_we bit (3-k). It places st_data[7:0] in mem_wdata bits [31-8k:24-8k] and drives every other lane to zero.
- R5: An aligned load drives mem_re high for exactly the one cycle after the request, with mem_we = 0 and mem_wdata = 0.
- R6: For a byte load at offset k, ld_data one clock after mem_re carries mem_rdata bits [31-8k:24-8k] in bits [7:0], and bit 7 of that byte copied into bits [31:8].
- R7: For a word load, ld_data one clock after mem_re equals the mem_rdata word unchanged.
- R8: A word access whose effective address has bits [1:0] not equal to zero raises misalign for one cycle and leaves mem_we = 0, mem_wdata = 0 and mem_re = 0. No ld_valid follows.
- R9: Byte accesses never raise misalign, whatever the offset.
- R10: ld_valid is high exactly one cycle after each cycle in which mem_re is high, and at no other time.
- R11: One clock after a cycle with no request, mem_we, mem_wdata, mem_re and misalign are all zero.
- R12: After reset, mem_addr, mem_we, mem_wdata, mem_re, misalign, ld_data and ld_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | Access kind: bit 1 store, bit 0 word |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register value |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write enables, bit 3 is the lane at bits [31:24] |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_re | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Word returned by memory while mem_re is high |
| misalign | output | 1 | A word access with an unaligned address was dropped |
| ld_data | output | 32 | Formatted load result |
| ld_valid | output | 1 | ld_data holds a new load result |

## Verification
The memory-side outputs (mem_addr, mem_we, mem_wdata, mem_re, misalign) are due one rising edge after the request. The bench drives each request on a falling edge and samples those outputs on the following falling edge. ld_data and ld_valid are due a second edge later. The bench withdraws the request after one cycle and samples the load result, together with the idle-cycle memory outputs, on the next falling edge. The bench memory answers from mem_addr without delay, so the expected word comes from the bench's own model of the address it should see.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;

    // Bit 1 selects a store, bit 0 selects a word access.
    typedef enum logic [1:0] {
        KIND_LD_BYTE = 2'b00,
        KIND_LD_WORD = 2'b01,
        KIND_ST_BYTE = 2'b10,
        KIND_ST_WORD = 2'b11
    } acc_kind_e;

    function automatic logic kind_is_store(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic kind_is_word(input logic [1:0] k);
        return k[0];
    endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int LANE_BITS = 2
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     disp,
    input  logic                 is_word,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [LANE_BITS-1:0] lane,
    output logic                 unaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff;

    always_comb begin
        disp_ext  = {{EXT_W{disp[OFF_W-1]}}, disp};
        eff       = base + disp_ext;
        lane      = eff[LANE_BITS-1:0];
        word_addr = {eff[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
        unaligned = is_word && (lane != '0);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int DATA_W    = 32,
    parameter int LANES     = DATA_W / 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic                 do_write,
    input  logic                 is_word,
    input  logic [LANE_BITS-1:0] lane,
    input  logic [DATA_W-1:0]    src,
    output logic [LANES-1:0]     we,
    output logic [DATA_W-1:0]    wdata
);
    // Big-endian: byte offset k lives in lane slot (LANES-1-k), the top bits.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int SLOT = LANES - 1 - g;
        logic hit;
        always_comb begin
            hit = do_write && (is_word || (lane == LANE_BITS'(g)));
            we[SLOT] = hit;
            if (!hit)
                wdata[SLOT*8 +: 8] = 8'h00;
            else if (is_word)
                wdata[SLOT*8 +: 8] = src[SLOT*8 +: 8];
            else
                wdata[SLOT*8 +: 8] = src[7:0];
        end
    end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
    parameter int DATA_W    = 32,
    parameter int LANES     = DATA_W / 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]    rdata,
    input  logic [LANE_BITS-1:0] lane,
    input  logic                 is_word,
    output logic [DATA_W-1:0]    result
);
    localparam int EXT_W = DATA_W - 8;

    logic [7:0] by_offset [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_pick
        assign by_offset[g] = rdata[(LANES-1-g)*8 +: 8];
    end

    always_comb begin
        picked = by_offset[lane];
        if (is_word)
            result = rdata;
        else
            result = {{EXT_W{picked[7]}}, picked};
    end
endmodule

// File: rtl/lsu_be_top.sv
module lsu_be_top
    import lsu_be_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] st_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              misalign,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_valid
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [LANES-1:0]     we;
        logic [DATA_W-1:0]    wdata;
        logic                 re;
        logic                 mis;
        logic [LANE_BITS-1:0] lane;
        logic                 word;
        logic [DATA_W-1:0]    ld;
        logic                 ld_v;
    } lsu_state_t;

    lsu_state_t s_d, s_q;

    logic [ADDR_W-1:0]    ea_word_d;
    logic [LANE_BITS-1:0] ea_lane_d;
    logic                 ea_bad_d;
    logic [LANES-1:0]     st_we_d;
    logic [DATA_W-1:0]    st_wdata_d;
    logic [DATA_W-1:0]    ld_fmt_d;
    logic                 is_word_d;
    logic                 is_store_d;

    assign is_word_d  = kind_is_word(req_kind);
    assign is_store_d = kind_is_store(req_kind);

    lsu_ea_calc #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .LANE_BITS(LANE_BITS)
    ) u_ea (
        .base     (base_addr),
        .disp     (offset),
        .is_word  (is_word_d),
        .word_addr(ea_word_d),
        .lane     (ea_lane_d),
        .unaligned(ea_bad_d)
    );

    lsu_store_lane #(
        .DATA_W   (DATA_W),
        .LANES    (LANES),
        .LANE_BITS(LANE_BITS)
    ) u_st (
        .do_write(req_valid && is_store_d && !ea_bad_d),
        .is_word (is_word_d),
        .lane    (ea_lane_d),
        .src     (st_data),
        .we      (st_we_d),
        .wdata   (st_wdata_d)
    );

    // Formats the word returned for the load held in the registered stage.
    lsu_load_fmt #(
        .DATA_W   (DATA_W),
        .LANES    (LANES),
        .LANE_BITS(LANE_BITS)
    ) u_ld (
        .rdata  (mem_rdata),
        .lane   (s_q.lane),
        .is_word(s_q.word),
        .result (ld_fmt_d)
    );

    always_comb begin
        s_d       = s_q;
        s_d.we    = '0;
        s_d.wdata = '0;
        s_d.re    = 1'b0;
        s_d.mis   = 1'b0;
        if (req_valid) begin
            s_d.addr  = ea_word_d;
            s_d.lane  = ea_lane_d;
            s_d.word  = is_word_d;
            s_d.mis   = ea_bad_d;
            s_d.we    = st_we_d;
            s_d.wdata = st_wdata_d;
            s_d.re    = !is_store_d && !ea_bad_d;
        end
        s_d.ld_v = s_q.re;
        if (s_q.re)
            s_d.ld = ld_fmt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign mem_addr  = s_q.addr;
    assign mem_we    = s_q.we;
    assign mem_wdata = s_q.wdata;
    assign mem_re    = s_q.re;
    assign misalign  = s_q.mis;
    assign ld_data   = s_q.ld;
    assign ld_valid  = s_q.ld_v;

endmodule

// File: rtl/lsu_be_chk.sv
module lsu_be_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] base_addr,
    input logic [OFF_W-1:0]  offset,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_re,
    input logic              misalign,
    input logic              ld_valid
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ea_chk;
    assign ea_chk = base_addr + {{EXT_W{offset[OFF_W-1]}}, offset};

    p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mem_addr == {$past(ea_chk[ADDR_W-1:2]), 2'b00});

    p_byte_store_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10) |=> $countones(mem_we) == 1);

    p_load_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[1]) |=> (mem_we == 4'b0000 && mem_wdata == '0));

    p_misalign_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_we == 4'b0000 && !mem_re));

    p_byte_never_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[0]) |=> !misalign);

    p_ld_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid);

    p_ld_valid_only_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !ld_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (mem_we == 4'b0000 && !mem_re && !misalign));

endmodule

bind lsu_be_top lsu_be_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFF_W (OFF_W)
) u_lsu_be_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .base_addr(base_addr),
    .offset   (offset),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .mem_re   (mem_re),
    .misalign (misalign),
    .ld_valid (ld_valid)
);

// File: tb/tb_lsu_be_top.sv
module tb_lsu_be_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic [31:0] mem_rdata;
    logic        misalign;
    logic [31:0] ld_data;
    logic        ld_valid;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_be_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .base_addr(base_addr), .offset(offset), .st_data(st_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .misalign(misalign),
        .ld_data(ld_data), .ld_valid(ld_valid)
    );

    // Bench memory: the word at an address is a fixed scramble of it.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A81_C37E;
    endfunction
    assign mem_rdata = mem_word(mem_addr);

    function automatic logic [31:0] eff_addr(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] kind, input logic [31:0] b,
                           input logic [15:0] o, input logic [31:0] sd);
        logic [31:0] ea, waddr, e_wdata, e_ld, word;
        logic [3:0]  e_we;
        logic [1:0]  k;
        logic        bad, e_re;
        logic [7:0]  byt;
        ea    = eff_addr(b, o);
        k     = ea[1:0];
        waddr = {ea[31:2], 2'b00};
        bad   = kind[0] && (k != 2'b00);
        e_we = 4'b0000; e_wdata = '0;
        if (kind[1] && !bad) begin
            if (kind[0]) begin e_we = 4'b1111; e_wdata = sd; end
            else begin
                e_we    = 4'b1000 >> k;
                e_wdata = {24'h0, sd[7:0]} << (8 * (3 - k));
            end
        end
        e_re = !kind[1] && !bad;
        word = mem_word(waddr);
        byt  = word[(31 - 8*k) -: 8];
        e_ld = kind[0] ? word : {{24{byt[7]}}, byt};

        req_valid = 1'b1; req_kind = kind; base_addr = b; offset = o; st_data = sd;
        @(negedge clk);
        check("R1", "mem_addr", mem_addr, waddr);
        if (kind == 2'b11) check("R3", "word store we", {28'h0, mem_we}, {28'h0, e_we});
        else if (kind == 2'b10) check("R4", "byte store we", {28'h0, mem_we}, {28'h0, e_we});
        else check("R5", "load we", {28'h0, mem_we}, 32'h0);
        check(kind[1] ? "R4" : "R5", "mem_wdata", mem_wdata, e_wdata);
        check("R5", "mem_re", {31'h0, mem_re}, {31'h0, e_re});
        check(kind[0] ? "R8" : "R9", "misalign", {31'h0, misalign}, {31'h0, bad});
        req_valid = 1'b0;
        st_data = $urandom;
        @(negedge clk);
        check("R10", "ld_valid", {31'h0, ld_valid}, {31'h0, e_re});
        if (e_re) check(kind[0] ? "R7" : "R6", "ld_data", ld_data, e_ld);
        check("R11", "idle outputs", {26'h0, mem_we, mem_re, misalign},
              32'h0);
        check("R11", "idle wdata", mem_wdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "reset addr", mem_addr, 32'h0);
        check("R12", "reset strobes",
              {25'h0, mem_we, mem_re, misalign, ld_valid}, 32'h0);
        check("R12", "reset wdata", mem_wdata, 32'h0);
        check("R12", "reset ld_data", ld_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners: every lane for byte stores and loads (R2 encodings).
        for (int k = 0; k < 4; k++) begin
            run_txn(2'b10, 32'h0000_1000, 16'(k), 32'hDEAD_BEA5);
            run_txn(2'b00, 32'h0000_2000, 16'(k), 32'h0);
        end
        run_txn(2'b11, 32'h0000_3004, 16'hFFFC, 32'h1234_5678); // negative offset
        run_txn(2'b01, 32'h0000_3000, 16'h0008, 32'h0);
        for (int k = 1; k < 4; k++) begin
            run_txn(2'b01, 32'h0000_4000, 16'(k), 32'h0);           // R8 load
            run_txn(2'b11, 32'h0000_4000, 16'(k), 32'hFFFF_FFFF);   // R8 store
        end
        run_txn(2'b00, 32'h7FFF_FFFF, 16'h8000, 32'h0);              // wrap
        // Search for byte loads with bit 7 both set and clear (R6).
        for (int a = 0; a < 16; a++) run_txn(2'b00, 32'h100 + 32'(a), 16'h0, 32'h0);

        void'($urandom(32'd20251));
        for (int i = 0; i < 400; i++) begin
            logic [15:0] o;
            o = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16) - 16'd8;
            run_txn(2'($urandom), $urandom, o, $urandom);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule